// File: doc/BRIEF.md
# Debug control and watchpoint unit

This block is the debug front end of a small 8-bit processor. A host tool feeds it a stream of command bytes. The block decodes them into writes and reads of an 8-bit debug control register and of three watchpoint registers: control, address and data. The control register drives two signals. `halt_fetch` stops the CPU from fetching new instructions. `reset_req` is a one-cycle request to reset the CPU. The block itself is cleared only by its own `rst_n`, which is the device reset. A reset that the block requests therefore leaves the debug state in place.

Debug mode can be entered in three ways: by a host write, by a break instruction decoded while breaks are enabled, or by a watchpoint event. All three sources share the same mode bit. When `rd_protect` is high, a host write can set that bit but cannot clear it. In that case only a device reset leaves debug mode. The watchpoint address comparator sits outside this block and consumes the `wpt_*_q` outputs.

Both byte streams use valid/ready handshakes. A command byte is taken on a rising edge where `cmd_in_valid` and `cmd_in_ready` are both high. A response byte is consumed on an edge where `rsp_out_valid` and `rsp_out_ready` are both high. While a response is pending, `cmd_in_ready` is low, so further host bytes wait. `rsp_out_valid` is never withdrawn and `rsp_out_data` never changes until the byte is consumed.

Top module: `dbg_ctl_unit`

## Requirements
- R1: After reset, `ctl_q`, all three watchpoint registers, `halt_fetch`, `reset_req` and `rsp_out_valid` are 0, and `cmd_in_ready` is 1.
- R2: The control register is laid out as follows. Bit 7 is the debug-mode flag. Bit 6 enables breaks. Bit 5 is the debug-acknowledge flag. Bit 0 requests a reset. Bits 4..1 always read 0. Command 0x04 followed by one byte writes the register. Command 0x05 returns one byte, which is the register value captured when 0x05 is accepted.
- R3: `halt_fetch` is 1 exactly while the debug-mode flag is 1.
- R4: A cycle with `brk_decoded` high sets the debug-mode flag on the next edge only if bit 6 is 1. A cycle with `wpt_break` high sets the flag unconditionally.
- R5: If a break event arrives in the same cycle as a host write that clears the debug-mode flag, the flag stays 1.
- R6: While `rd_protect` is 1, a host write cannot clear the debug-mode flag. Such a write can still set it and can change the other bits.
- R7: Writing 0x81 raises `reset_req` for exactly the one cycle after the write is taken. Bit 0 then reads 0 again, and the debug-mode flag stays 1.
- R8: Writing 0x40 while in debug mode clears the debug-mode flag, leaves bit 6 set, and raises no reset request.
- R9: Command 0x20 followed by three bytes loads the watchpoint control, address and data registers, in that order.
- R10: The watchpoint control byte of a 0x20 command is replaced by 0x00 if the debug-mode flag is 0 or `rd_protect` is 1 when that byte is taken.
- R11: Command 0x21 returns the control, address and data bytes, in that order. `cmd_in_ready` stays 0 until the last byte is consumed, and each byte is held stable while `rsp_out_ready` is low.
- R12: An unknown command byte is accepted and discarded. It changes no register, and the unit waits for the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| rd_protect | input | 1 | Read protection active |
| brk_decoded | input | 1 | CPU decoded a break instruction |
| wpt_break | input | 1 | Watchpoint break event |
| cmd_in_valid | input | 1 | Host command byte valid |
| cmd_in_ready | output | 1 | Unit accepts a command byte |
| cmd_in_data | input | 8 | Host command byte |
| rsp_out_valid | output | 1 | Response byte valid |
| rsp_out_ready | input | 1 | Host consumes response byte |
| rsp_out_data | output | 8 | Response byte |
| halt_fetch | output | 1 | Stop instruction fetch |
| reset_req | output | 1 | One-cycle CPU reset request |
| ctl_q | output | 8 | Debug control register |
| wpt_ctl_q | output | 8 | Watchpoint control register |
| wpt_addr_q | output | 8 | Watchpoint address register |
| wpt_data_q | output | 8 | Watchpoint data register |

## Verification
All register effects appear one edge after the final byte of a command is taken, or one edge after a break event. `halt_fetch` follows the flag within that same cycle, and `reset_req` stays high for the single cycle after that edge. A response byte is valid in the cycle after its command byte is taken, and each following byte is valid in the cycle after the previous one is consumed. The bench drives inputs and samples outputs on the falling edge. It checks each result at the first falling edge after the rising edge that causes it, and it checks the next falling edge as well where a value must self-clear or be held.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int BYTE_W   = 8;
  localparam int WPT_REGS = 3;
  localparam int IDX_W    = 2;

  localparam logic [BYTE_W-1:0] OP_WPT_WR = 8'h20;
  localparam logic [BYTE_W-1:0] OP_WPT_RD = 8'h21;
  localparam logic [BYTE_W-1:0] OP_CTL_WR = 8'h04;
  localparam logic [BYTE_W-1:0] OP_CTL_RD = 8'h05;

  localparam int B_MODE = 7;
  localparam int B_BRK  = 6;
  localparam int B_ACK  = 5;
  localparam int B_RST  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WPT_WR, ST_WPT_RD, ST_CTL_WR, ST_CTL_RD
  } cmd_st_e;
endpackage

// File: rtl/dbg_cmd_fsm.sv
module dbg_cmd_fsm
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              ctl_we,
  output logic              snap_en,
  output logic [WPT_REGS-1:0] wpt_we,
  output logic              sel_ctl,
  output logic [IDX_W-1:0]  rd_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WPT_REGS - 1);

  cmd_st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic acc, pop;

  assign in_ready  = (st_q == ST_IDLE) || (st_q == ST_WPT_WR) || (st_q == ST_CTL_WR);
  assign out_valid = (st_q == ST_WPT_RD) || (st_q == ST_CTL_RD);
  assign acc = in_valid && in_ready;
  assign pop = out_valid && out_ready;
  assign sel_ctl = (st_q == ST_CTL_RD);
  assign rd_idx  = idx_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    ctl_we  = 1'b0;
    snap_en = 1'b0;
    wpt_we  = '0;
    case (st_q)
      ST_IDLE: if (acc) begin
        idx_d = '0;
        case (in_data)
          OP_WPT_WR: st_d = ST_WPT_WR;
          OP_WPT_RD: st_d = ST_WPT_RD;
          OP_CTL_WR: st_d = ST_CTL_WR;
          OP_CTL_RD: begin st_d = ST_CTL_RD; snap_en = 1'b1; end
          default:   st_d = ST_IDLE;
        endcase
      end
      ST_WPT_WR: if (acc) begin
        wpt_we = WPT_REGS'(1) << idx_q;
        if (idx_q == LAST) begin st_d = ST_IDLE; idx_d = '0; end
        else idx_d = idx_q + 1'b1;
      end
      ST_CTL_WR: if (acc) begin
        ctl_we = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_WPT_RD: if (pop) begin
        if (idx_q == LAST) begin st_d = ST_IDLE; idx_d = '0; end
        else idx_d = idx_q + 1'b1;
      end
      ST_CTL_RD: if (pop) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_protect,
  input  logic              brk_decoded,
  input  logic              wpt_break,
  output logic [BYTE_W-1:0] ctl_q
);
  logic [BYTE_W-1:0] ctl_d;
  logic brk_hit;

  assign brk_hit = (brk_decoded && ctl_q[B_BRK]) || wpt_break;

  always_comb begin
    ctl_d = ctl_q;
    ctl_d[B_RST] = 1'b0;
    if (wr_en) begin
      ctl_d[B_MODE] = wr_data[B_MODE] || (rd_protect && ctl_q[B_MODE]);
      ctl_d[B_BRK]  = wr_data[B_BRK];
      ctl_d[B_ACK]  = wr_data[B_ACK];
      ctl_d[B_RST]  = wr_data[B_RST];
    end
    if (brk_hit) ctl_d[B_MODE] = 1'b1;
    ctl_d[B_ACK-1:B_RST+1] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/dbg_wpt_regs.sv
module dbg_wpt_regs
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WPT_REGS-1:0] we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              zero_ctl,
  output logic [WPT_REGS-1:0][BYTE_W-1:0] regs_q
);
  for (genvar g = 0; g < WPT_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] load_val;
    if (g == 0) begin : g_ctl
      assign load_val = zero_ctl ? '0 : wr_data;
    end else begin : g_plain
      assign load_val = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (we[g]) regs_q[g] <= load_val;
    end
  end
endmodule

// File: rtl/dbg_ctl_unit.sv
module dbg_ctl_unit
  import dbg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_protect,
  input  logic        brk_decoded,
  input  logic        wpt_break,
  input  logic        cmd_in_valid,
  output logic        cmd_in_ready,
  input  logic [7:0]  cmd_in_data,
  output logic        rsp_out_valid,
  input  logic        rsp_out_ready,
  output logic [7:0]  rsp_out_data,
  output logic        halt_fetch,
  output logic        reset_req,
  output logic [7:0]  ctl_q,
  output logic [7:0]  wpt_ctl_q,
  output logic [7:0]  wpt_addr_q,
  output logic [7:0]  wpt_data_q
);
  logic ctl_we, snap_en, sel_ctl;
  logic [WPT_REGS-1:0] wpt_we;
  logic [IDX_W-1:0] rd_idx;
  logic [WPT_REGS-1:0][BYTE_W-1:0] wpt_q;
  logic [BYTE_W-1:0] ctl_r, snap_q;

  dbg_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_in_valid), .in_ready(cmd_in_ready), .in_data(cmd_in_data),
    .out_valid(rsp_out_valid), .out_ready(rsp_out_ready),
    .ctl_we(ctl_we), .snap_en(snap_en), .wpt_we(wpt_we),
    .sel_ctl(sel_ctl), .rd_idx(rd_idx)
  );

  dbg_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_data(cmd_in_data),
    .rd_protect(rd_protect), .brk_decoded(brk_decoded),
    .wpt_break(wpt_break), .ctl_q(ctl_r)
  );

  dbg_wpt_regs u_wpt (
    .clk(clk), .rst_n(rst_n), .we(wpt_we), .wr_data(cmd_in_data),
    .zero_ctl(!ctl_r[B_MODE] || rd_protect), .regs_q(wpt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= ctl_r;
  end

  always_comb begin
    rsp_out_data = '0;
    if (sel_ctl) rsp_out_data = snap_q;
    else if (rd_idx < IDX_W'(WPT_REGS)) rsp_out_data = wpt_q[rd_idx];
  end

  assign ctl_q      = ctl_r;
  assign halt_fetch = ctl_r[B_MODE];
  assign reset_req  = ctl_r[B_RST];
  assign wpt_ctl_q  = wpt_q[0];
  assign wpt_addr_q = wpt_q[1];
  assign wpt_data_q = wpt_q[2];
endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_protect,
  input logic       brk_decoded,
  input logic       wpt_break,
  input logic       cmd_in_ready,
  input logic       rsp_out_valid,
  input logic       rsp_out_ready,
  input logic [7:0] rsp_out_data,
  input logic       reset_req,
  input logic [7:0] ctl_q
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4:1] == 4'd0);
  assert_brk_sets_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_decoded && ctl_q[6]) |=> ctl_q[7]);
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wpt_break |=> ctl_q[7]);
  assert_protect_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_protect && ctl_q[7]) |=> ctl_q[7]);
  assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_out_valid && !rsp_out_ready) |=> (rsp_out_valid && $stable(rsp_out_data)));
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_in_ready && rsp_out_valid));
endmodule

bind dbg_ctl_unit dbg_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_protect(rd_protect), .brk_decoded(brk_decoded),
  .wpt_break(wpt_break), .cmd_in_ready(cmd_in_ready), .rsp_out_valid(rsp_out_valid),
  .rsp_out_ready(rsp_out_ready), .rsp_out_data(rsp_out_data),
  .reset_req(reset_req), .ctl_q(ctl_q)
);

// File: tb/sim_dbg_ctl_unit.sv
module sim_dbg_ctl_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_protect = 1'b0, brk_decoded = 1'b0, wpt_break = 1'b0;
  logic cmd_in_valid = 1'b0, rsp_out_ready = 1'b0;
  logic [7:0] cmd_in_data = 8'h00;
  logic cmd_in_ready, rsp_out_valid, halt_fetch, reset_req;
  logic [7:0] rsp_out_data, ctl_q, wpt_ctl_q, wpt_addr_q, wpt_data_q;
  int checks = 0, failures = 0;
  logic [7:0] rb;

  always #5 clk = ~clk;

  dbg_ctl_unit u0 (
    .clk(clk), .rst_n(rst_n), .rd_protect(rd_protect), .brk_decoded(brk_decoded),
    .wpt_break(wpt_break), .cmd_in_valid(cmd_in_valid), .cmd_in_ready(cmd_in_ready),
    .cmd_in_data(cmd_in_data), .rsp_out_valid(rsp_out_valid),
    .rsp_out_ready(rsp_out_ready), .rsp_out_data(rsp_out_data),
    .halt_fetch(halt_fetch), .reset_req(reset_req), .ctl_q(ctl_q),
    .wpt_ctl_q(wpt_ctl_q), .wpt_addr_q(wpt_addr_q), .wpt_data_q(wpt_data_q)
  );

  // {protect, written byte, expected register, expected reset pulse}
  localparam logic [17:0] VEC [0:6] = '{
    {1'b0, 8'hC0, 8'hC0, 1'b0},  // R2 enter debug, enable breaks
    {1'b0, 8'h40, 8'h40, 1'b0},  // R8 run
    {1'b0, 8'hFE, 8'hE0, 1'b0},  // R2 reserved bits read 0
    {1'b1, 8'h00, 8'h80, 1'b0},  // R6 clear blocked
    {1'b1, 8'h20, 8'hA0, 1'b0},  // R6 other bits still change
    {1'b0, 8'h81, 8'h80, 1'b1},  // R7 reset and stop
    {1'b0, 8'h00, 8'h00, 1'b0}   // R2 clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic evt);
    cmd_in_valid = 1'b1; cmd_in_data = b; wpt_break = evt;
    while (!cmd_in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_in_valid = 1'b0; wpt_break = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    rsp_out_ready = 1'b1;
    while (!rsp_out_valid) @(negedge clk);
    b = rsp_out_data;
    @(posedge clk);
    @(negedge clk);
    rsp_out_ready = 1'b0;
  endtask

  task automatic pulse_brk(input logic instr);
    if (instr) brk_decoded = 1'b1; else wpt_break = 1'b1;
    @(negedge clk);
    brk_decoded = 1'b0; wpt_break = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctl", ctl_q, 8'h00);
    check("R1 wpt", {wpt_ctl_q, wpt_addr_q, wpt_data_q}, 24'h0);
    check("R1 halt/rst/valid/ready", {halt_fetch, reset_req, rsp_out_valid, cmd_in_ready}, 4'b0001);

    for (int i = 0; i < 7; i++) begin
      rd_protect = VEC[i][17];
      send(8'h04, 1'b0);
      send(VEC[i][16:9], 1'b0);
      check("R2 R6 R8 ctl after write", ctl_q & 8'hFE, {24'h0, VEC[i][8:1]});
      check("R7 reset pulse", reset_req, VEC[i][0]);
      check("R3 halt follows mode", halt_fetch, VEC[i][8]);
      @(negedge clk);
      check("R7 self clear", {reset_req, ctl_q}, {1'b0, VEC[i][8:1]});
      if (i == 2) begin
        send(8'h05, 1'b0);
        recv(rb);
        check("R2 control readback", rb, 8'hE0);
      end
    end
    rd_protect = 1'b0;

    pulse_brk(1'b1);
    check("R4 break ignored when disabled", ctl_q, 8'h00);
    send(8'h04, 1'b0); send(8'h40, 1'b0);
    pulse_brk(1'b1);
    check("R4 break instruction sets mode", ctl_q, 8'hC0);
    check("R3 halt high", halt_fetch, 1'b1);
    send(8'h04, 1'b0); send(8'h00, 1'b0);
    check("R3 halt low", halt_fetch, 1'b0);
    pulse_brk(1'b0);
    check("R4 watchpoint event sets mode", ctl_q, 8'h80);

    send(8'h04, 1'b0); send(8'h00, 1'b1);
    check("R5 event beats clearing write", ctl_q, 8'h80);

    send(8'h20, 1'b0); send(8'h5A, 1'b0); send(8'h12, 1'b0); send(8'h34, 1'b0);
    check("R9 load order", {wpt_ctl_q, wpt_addr_q, wpt_data_q}, 24'h5A1234);
    send(8'h21, 1'b0);
    check("R11 first byte valid", {rsp_out_valid, cmd_in_ready, rsp_out_data}, {2'b10, 8'h5A});
    repeat (3) @(negedge clk);
    check("R11 held under back-pressure", {rsp_out_valid, cmd_in_ready, rsp_out_data}, {2'b10, 8'h5A});
    recv(rb); check("R11 byte 0", rb, 8'h5A);
    recv(rb); check("R11 byte 1", rb, 8'h12);
    check("R11 ready low mid-response", cmd_in_ready, 1'b0);
    recv(rb); check("R11 byte 2", rb, 8'h34);
    check("R11 back to command wait", {cmd_in_ready, rsp_out_valid}, 2'b10);

    rd_protect = 1'b1;
    send(8'h20, 1'b0); send(8'h77, 1'b0); send(8'h56, 1'b0); send(8'h78, 1'b0);
    check("R10 protected zeroes control", {wpt_ctl_q, wpt_addr_q, wpt_data_q}, 24'h005678);
    rd_protect = 1'b0;
    send(8'h04, 1'b0); send(8'h00, 1'b0);
    send(8'h20, 1'b0); send(8'h33, 1'b0); send(8'h44, 1'b0); send(8'h55, 1'b0);
    check("R10 not in debug zeroes control", {wpt_ctl_q, wpt_addr_q, wpt_data_q}, 24'h004455);

    send(8'h99, 1'b0);
    check("R12 unknown code ignored", {cmd_in_ready, rsp_out_valid, ctl_q}, {2'b10, 8'h00});
    send(8'h05, 1'b0);
    recv(rb);
    check("R12 next command decoded", rb, 8'h00);
    check("R12 watchpoints untouched", {wpt_ctl_q, wpt_addr_q, wpt_data_q}, 24'h004455);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule